// File: doc/BRIEF.md
# Write-Through Cache Controller with Snoop Invalidation

This block controls a small direct-mapped cache that holds one data word per line and writes through to memory. A single valid bit per line is the whole coherence state. A read that finds a valid line with a matching tag returns data in the same cycle. Any other read fetches the word from memory, returns it, and marks the line valid. A processor write first requests the shared bus and waits for the external grant. It then drives the write onto the bus and to memory together. When memory acknowledges, the local line is updated if it holds that address. A write that misses leaves the cache untouched.

Other controllers' writes arrive on the snoop input. When a snooped address matches the full address held by the line at that index, the line is cleared. A snoop to the same index with a different tag leaves the line alone. Once a write has finished, the only current copies are in memory and in the writer's cache. Arbitration between controllers lies outside the block and appears here as a single grant input.

Top module: `wt_snoop_cache`

## Requirements
- R1: After reset every line is invalid, and `cpu_ack_o`, `bus_req_o` and `mem_req_o` are low; the first read of any address goes to memory.
- R2: A read miss raises `mem_req_o` with `mem_we_o` low until `mem_ack_i`. In that cycle `cpu_ack_o` is high and `cpu_rdata_o` equals `mem_rdata_i`, and the line is filled and made valid.
- R3: A read of a valid line whose tag (`cpu_addr_i[ADDR_W-1:IDX_W]`, index `cpu_addr_i[IDX_W-1:0]`) matches acks in the request cycle with the stored word, and `mem_req_o` stays low.
- R4: A write raises `bus_req_o` and stalls with `cpu_ack_o` low. Neither `bus_wr_o` nor a memory write occurs until `bus_gnt_i` is seen.
- R5: After the grant, `bus_wr_o`, `mem_req_o` and `mem_we_o` are high with the write address and data until `mem_ack_i`, and `cpu_ack_o` rises in that cycle. A write hit updates the cached word and the line stays valid.
- R6: A write miss does not allocate and does not disturb the line at that index.
- R7: A snooped write (`snp_valid_i`) whose address equals the address held in a valid line invalidates that line. A snoop to the same index with another tag leaves the line valid.
- R8: If a snoop invalidates the line that a local read hits in the same cycle, the read is not acked that cycle and is served as a miss.
- R9: If a snoop to the address being filled occurs in the fill cycle, the data is still returned but the line is left invalid.
- R10: A read of a different tag at an occupied index misses and replaces the line, so that the old address then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor request, held until ack |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | ADDR_W | Word address |
| cpu_wdata_i | input | DATA_W | Write data |
| cpu_ack_o | output | 1 | Request complete |
| cpu_rdata_o | output | DATA_W | Read data, valid with ack |
| bus_req_o | output | 1 | Bus request for a write |
| bus_gnt_i | input | 1 | Bus grant from the external arbiter |
| bus_wr_o | output | 1 | Write broadcast on the shared bus |
| bus_addr_o | output | ADDR_W | Broadcast address |
| bus_wdata_o | output | DATA_W | Broadcast data |
| snp_valid_i | input | 1 | Write by another agent observed on the bus |
| snp_addr_i | input | ADDR_W | Address of the observed write |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_rdata_i | input | DATA_W | Memory read data |
| mem_ack_i | input | 1 | Memory completion |

## Verification
Reads are tried against an empty line, a valid matching line, and a valid line holding another tag at the same index. These cases separate hits from misses and show that the tag, not the slot, decides. Writes are issued both to a cached address and to an uncached one sharing an occupied index, which shows update-in-place apart from no-write-allocate. Grant delays of zero and several cycles show that the stall holds. Snoops are applied to a matching address, to a same-index/other-tag address, in the same cycle as a read hit, and in the fill cycle. These cases cover invalidation, its tag check and the two priority rules.

// File: rtl/wt_cache_pkg.sv
package wt_cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_ARB  = 2'd2,
    ST_WBUS = 2'd3
  } ctl_state_e;
endpackage

// File: rtl/wt_line_store.sv
module wt_line_store #(
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_valid_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              snp_en_i,
  input  logic [IDX_W-1:0]  snp_idx_i,
  input  logic [TAG_W-1:0]  snp_tag_i,
  output logic              snp_kill_o,
  input  logic              fill_en_i,
  input  logic              upd_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];
  logic              fill_snooped;

  assign snp_kill_o   = snp_en_i && valid_q[snp_idx_i] && (tag_q[snp_idx_i] == snp_tag_i);
  // snoop to the very address being filled keeps the new line invalid
  assign fill_snooped = snp_en_i && (snp_idx_i == wr_idx_i) && (snp_tag_i == wr_tag_i);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g] <= 1'b0;
      end else if (fill_en_i && wr_idx_i == IDX_W'(g)) begin
        valid_q[g] <= !fill_snooped;
      end else if (snp_kill_o && snp_idx_i == IDX_W'(g)) begin
        valid_q[g] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_en_i || upd_en_i) data_q[wr_idx_i] <= wr_data_i;
    if (fill_en_i)             tag_q[wr_idx_i]  <= wr_tag_i;
  end

  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_tag_o   = tag_q[rd_idx_i];
  assign rd_data_o  = data_q[rd_idx_i];
endmodule

// File: rtl/wt_ctl_fsm.sv
module wt_ctl_fsm
  import wt_cache_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic we_i,
  input  logic rd_hit_i,
  input  logic line_match_i,
  input  logic bus_gnt_i,
  input  logic mem_ack_i,
  output logic ack_o,
  output logic bus_req_o,
  output logic bus_wr_o,
  output logic mem_req_o,
  output logic mem_we_o,
  output logic fill_en_o,
  output logic upd_en_o
);
  ctl_state_e st_q, st_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  always_comb begin
    st_d      = st_q;
    ack_o     = 1'b0;
    bus_req_o = 1'b0;
    bus_wr_o  = 1'b0;
    mem_req_o = 1'b0;
    mem_we_o  = 1'b0;
    fill_en_o = 1'b0;
    upd_en_o  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_i) begin
          if (we_i)          st_d  = ST_ARB;
          else if (rd_hit_i) ack_o = 1'b1;
          else               st_d  = ST_FILL;
        end
      end
      ST_FILL: begin
        mem_req_o = 1'b1;
        if (mem_ack_i) begin
          ack_o     = 1'b1;
          fill_en_o = 1'b1;
          st_d      = ST_IDLE;
        end
      end
      ST_ARB: begin
        bus_req_o = 1'b1;
        if (bus_gnt_i) st_d = ST_WBUS;
      end
      ST_WBUS: begin
        bus_req_o = 1'b1;
        bus_wr_o  = 1'b1;
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
        if (mem_ack_i) begin
          ack_o    = 1'b1;
          upd_en_o = line_match_i;  // no-write-allocate
          st_d     = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/wt_snoop_cache.sv
module wt_snoop_cache #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ack_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic              bus_wr_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic              snp_valid_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ack_i
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  cpu_idx, snp_idx;
  logic [TAG_W-1:0]  cpu_tag, snp_tag, rd_tag;
  logic              rd_valid, snp_kill, line_match, rd_hit;
  logic [DATA_W-1:0] rd_data, wr_data;
  logic              fill_en, upd_en;

  assign cpu_idx = cpu_addr_i[IDX_W-1:0];
  assign cpu_tag = cpu_addr_i[ADDR_W-1:IDX_W];
  assign snp_idx = snp_addr_i[IDX_W-1:0];
  assign snp_tag = snp_addr_i[ADDR_W-1:IDX_W];

  wt_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) i_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (cpu_idx),
    .rd_valid_o (rd_valid),
    .rd_tag_o   (rd_tag),
    .rd_data_o  (rd_data),
    .snp_en_i   (snp_valid_i),
    .snp_idx_i  (snp_idx),
    .snp_tag_i  (snp_tag),
    .snp_kill_o (snp_kill),
    .fill_en_i  (fill_en),
    .upd_en_i   (upd_en),
    .wr_idx_i   (cpu_idx),
    .wr_tag_i   (cpu_tag),
    .wr_data_i  (wr_data)
  );

  assign line_match = rd_valid && (rd_tag == cpu_tag);
  // a same-cycle invalidation of the looked-up line turns the hit into a miss
  assign rd_hit     = line_match && !(snp_kill && snp_idx == cpu_idx);
  assign wr_data    = fill_en ? mem_rdata_i : cpu_wdata_i;

  wt_ctl_fsm i_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (cpu_req_i),
    .we_i         (cpu_we_i),
    .rd_hit_i     (rd_hit),
    .line_match_i (line_match),
    .bus_gnt_i    (bus_gnt_i),
    .mem_ack_i    (mem_ack_i),
    .ack_o        (cpu_ack_o),
    .bus_req_o    (bus_req_o),
    .bus_wr_o     (bus_wr_o),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .fill_en_o    (fill_en),
    .upd_en_o     (upd_en)
  );

  assign cpu_rdata_o = mem_req_o ? mem_rdata_i : rd_data;
  assign bus_addr_o  = cpu_addr_i;
  assign bus_wdata_o = cpu_wdata_i;
  assign mem_addr_o  = cpu_addr_i;
  assign mem_wdata_o = cpu_wdata_i;
endmodule

// File: rtl/wt_snoop_cache_chk.sv
module wt_snoop_cache_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_req_i,
  input logic              cpu_we_i,
  input logic [ADDR_W-1:0] cpu_addr_i,
  input logic              cpu_ack_o,
  input logic              bus_req_o,
  input logic              bus_gnt_i,
  input logic              bus_wr_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic              snp_valid_i,
  input logic [ADDR_W-1:0] snp_addr_i,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [DATA_W-1:0] mem_rdata_i,
  input logic [DATA_W-1:0] cpu_rdata_o,
  input logic              mem_ack_i
);
  AST_ACK_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ack_o |-> cpu_req_i); // R3
  AST_FILL_ACK_WITH_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_ack_o && !cpu_we_i && mem_req_o) |-> (mem_ack_i && !mem_we_o && cpu_rdata_o == mem_rdata_i)); // R2
  AST_STALL_WHILE_ARB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_wr_o) |-> (!cpu_ack_o && !mem_req_o)); // R4
  AST_BUS_WR_AFTER_GNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_wr_o) |-> $past(bus_gnt_i)); // R4
  AST_MEM_WR_ON_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> (bus_wr_o && bus_addr_o == cpu_addr_i)); // R5
  AST_WR_ACK_WITH_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_ack_o && cpu_we_i) |-> (mem_ack_i && bus_wr_o)); // R5
  AST_SNOOP_BEATS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && !cpu_we_i && !mem_req_o && snp_valid_i && snp_addr_i == cpu_addr_i) |-> !cpu_ack_o); // R8
endmodule

bind wt_snoop_cache wt_snoop_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_wt_snoop_cache.sv
`timescale 1ns/1ps
module test_wt_snoop_cache;
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic          cpu_ack;
  logic [DW-1:0] cpu_rdata;
  logic          bus_req, bus_wr;
  logic          bus_gnt = 1'b0;
  logic [AW-1:0] bus_addr, mem_addr;
  logic [DW-1:0] bus_wdata, mem_wdata, mem_rdata;
  logic          snp_valid = 1'b0;
  logic [AW-1:0] snp_addr = '0;
  logic          mem_req, mem_we;
  logic          mem_ack;
  logic [1:0]    mem_cnt;
  logic [DW-1:0] mem_m [0:255];

  int n_checks = 0;
  int n_errors = 0;

  always #4 clk = ~clk;

  wt_snoop_cache i_wt_snoop_cache (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_ack_o(cpu_ack), .cpu_rdata_o(cpu_rdata),
    .bus_req_o(bus_req), .bus_gnt_i(bus_gnt), .bus_wr_o(bus_wr),
    .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata),
    .snp_valid_i(snp_valid), .snp_addr_i(snp_addr),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack)
  );

  // memory model: ack two cycles after request, write at the ack edge
  assign mem_rdata = mem_m[mem_addr[7:0]];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      mem_cnt <= '0;
    end else if (mem_ack || !mem_req) begin
      if (mem_ack && mem_req && mem_we) mem_m[mem_addr[7:0]] <= mem_wdata;
      mem_ack <= 1'b0;
      mem_cnt <= '0;
    end else begin
      mem_cnt <= mem_cnt + 2'd1;
      mem_ack <= (mem_cnt == 2'd1);
    end
  end

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic wait_ack();
    for (int n = 0; n < 40 && !cpu_ack; n++) begin
      @(negedge clk); #1;
    end
  endtask

  // read; snp_same = snoop same address in request cycle, snp_fill = snoop in fill cycle
  task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp, input bit exp_hit,
                         input bit snp_same, input bit snp_fill, input string rq);
    bit hit;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
    if (snp_same) begin
      snp_valid = 1'b1; snp_addr = a; mem_m[a[7:0]] = exp;
    end
    #1;
    hit = cpu_ack && !mem_req;
    if (snp_same) begin
      check(!cpu_ack, rq, "ack while snooped", {31'd0, cpu_ack}, 32'd0);
      @(negedge clk); snp_valid = 1'b0; #1;
    end
    check(hit == exp_hit, rq, "hit", {31'd0, hit}, {31'd0, exp_hit});
    wait_ack();
    if (snp_fill) begin
      snp_valid = 1'b1; snp_addr = a;
    end
    check(cpu_ack && cpu_rdata == exp, rq, "read data", cpu_rdata, exp);
    @(negedge clk);
    cpu_req = 1'b0; snp_valid = 1'b0;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input int gdelay,
                          input string rq);
    bit stall_ok = 1'b1;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d; bus_gnt = 1'b0;
    for (int i = 0; i < gdelay; i++) begin
      @(negedge clk); #1;
      if (!bus_req || bus_wr || cpu_ack || mem_req) stall_ok = 1'b0;
    end
    if (gdelay > 0) check(stall_ok, "R4", "stall before grant", {31'd0, stall_ok}, 32'd1);
    bus_gnt = 1'b1;
    @(negedge clk); #1;
    wait_ack();
    check(cpu_ack && bus_wr && mem_we && bus_addr == a && bus_wdata == d, rq,
          "bus write at ack", bus_wdata, d);
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0; bus_gnt = 1'b0;
    check(mem_m[a[7:0]] == d, "R5", "memory updated", mem_m[a[7:0]], d);
  endtask

  task automatic snoop(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    snp_valid = 1'b1; snp_addr = a; mem_m[a[7:0]] = d;
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    check(!cpu_ack && !bus_req && !mem_req, "R1", "outputs idle after reset",
          {29'd0, cpu_ack, bus_req, mem_req}, 32'd0);
    do_read(16'h0005, 32'hA000_0005, 1'b0, 1'b0, 1'b0, "R1");  // R2 fill
  endtask

  task automatic t_hit();
    do_read(16'h0005, 32'hA000_0005, 1'b1, 1'b0, 1'b0, "R3");
  endtask

  task automatic t_write_hit();
    do_write(16'h0005, 32'h1111_1111, 3, "R5");
    do_read(16'h0005, 32'h1111_1111, 1'b1, 1'b0, 1'b0, "R5");
  endtask

  task automatic t_write_miss();
    do_write(16'h0033, 32'h2222_2222, 0, "R6");
    do_read(16'h0033, 32'h2222_2222, 1'b0, 1'b0, 1'b0, "R6");
    do_write(16'h0015, 32'h6666_6666, 1, "R6");
    do_read(16'h0005, 32'h1111_1111, 1'b1, 1'b0, 1'b0, "R6");
  endtask

  task automatic t_snoop();
    snoop(16'h0005, 32'h3333_3333);
    do_read(16'h0005, 32'h3333_3333, 1'b0, 1'b0, 1'b0, "R7");
    snoop(16'h0025, 32'h4444_4444);
    do_read(16'h0005, 32'h3333_3333, 1'b1, 1'b0, 1'b0, "R7");
  endtask

  task automatic t_replace();
    do_read(16'h0015, 32'h6666_6666, 1'b0, 1'b0, 1'b0, "R10");
    do_read(16'h0005, 32'h3333_3333, 1'b0, 1'b0, 1'b0, "R10");
  endtask

  task automatic t_snoop_vs_read();
    do_read(16'h0005, 32'h5555_5555, 1'b0, 1'b1, 1'b0, "R8");
    do_read(16'h0005, 32'h5555_5555, 1'b1, 1'b0, 1'b0, "R8");
  endtask

  task automatic t_snoop_in_fill();
    do_read(16'h0007, 32'hA000_0007, 1'b0, 1'b0, 1'b1, "R9");
    do_read(16'h0007, 32'hA000_0007, 1'b0, 1'b0, 1'b0, "R9");
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem_m[i] = 32'hA000_0000 + i;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_hit();
    t_write_hit();
    t_write_miss();
    t_snoop();
    t_replace();
    t_snoop_vs_read();
    t_snoop_in_fill();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule